// File: doc/BRIEF.md
# Floating-Point Special-Operand Screen

This block sits on both sides of a floating-point arithmetic core. On the way in, it sorts each source operand of an instruction into one of six classes: zero, denormal, normal, infinity, quiet NaN or signalling NaN. It then picks one of three outcomes. The operands can go to the core, the core's work can be replaced by the default quiet NaN, or an invalid-operation trap can be raised so that the destination register keeps its old value. While doing this it zeroes denormal operands when flush mode is on. On the way out, it takes the core's result and applies the same denormal flush.

The NaN convention is the reverse of the usual one. A set top fraction bit marks a *signalling* NaN, which is why the default quiet NaN has that bit clear. Moves, absolute value and negation are plain bit transfers. They bypass classification effects, trapping and flushing completely. One precision-select input switches between the 32-bit layout, held in the low half of each 64-bit port, and the 64-bit layout.

Top module: `fp_special_unit`

## Requirements
- R1: With an all-ones exponent and a non-zero fraction, a fraction MSB (bit 22 single, bit 51 double) of 1 marks a signalling NaN and a fraction MSB of 0 marks a quiet NaN.
- R2: `dec_valid` rises the cycle after `in_valid` and is low in any cycle not preceded by `in_valid`. After reset all outputs read zero.
- R3: For an arithmetic operation (`op_kind`=0), a used signalling-NaN operand with `inv_en`=0 gives `outcome`=1 (default NaN), `exc_invalid`=0 and `wr_en`=1.
- R4: For an arithmetic operation, a used signalling-NaN operand with `inv_en`=1 gives `outcome`=2 (trap), `exc_invalid`=1 and `wr_en`=0. This holds even if another operand is a quiet NaN.
- R5: A used quiet-NaN operand with no used signalling NaN gives `outcome`=1, `exc_invalid`=0 and `wr_en`=1, whatever the value of `inv_en`.
- R6: `qnan_out` carries 0x7FBFFFFF (single, upper 32 bits zero) or 0x7FF7FFFFFFFFFFFF (double) when `outcome`=1, and zero otherwise.
- R7: For arithmetic operations with `flush_en`=1, a used denormal operand (exponent zero, fraction non-zero) comes out as a zero that keeps its sign. With `flush_en`=0 it comes out unchanged.
- R8: `res_valid` follows `core_valid` by one cycle. `res_out` is `core_res` with a denormal replaced by a signed zero when `flush_en`=1 and `op_kind`=0, and unchanged otherwise.
- R9: Copy (`op_kind`=1), absolute value (2) and negate (3) give `outcome`=0, no trap and `wr_en`=1. Their operands and results pass unflushed for every input value.
- R10: An operand whose `use_mask` bit is 0 has no effect on the outcome and is passed out unflushed.
- R11: With `dbl`=0 only bits 31:0 of each value are examined, and bits 63:32 of `opnd_out` lanes, `res_out` and `qnan_out` are zero.
- R12: An all-ones exponent with a zero fraction (infinity) is not a NaN. On its own it gives `outcome`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand set present this cycle |
| dbl | input | 1 | 1 = 64-bit layout, 0 = 32-bit layout in low half |
| op_kind | input | 2 | 0 arithmetic, 1 copy, 2 absolute, 3 negate |
| use_mask | input | NSRC | Per-operand "operand is read" flags |
| inv_en | input | 1 | Invalid-operation trap enable |
| flush_en | input | 1 | Denormal flush-to-zero mode |
| opnd_in | input | NSRC*64 | Source operands, lane i in bits 64i+63:64i |
| dec_valid | output | 1 | Decision outputs valid |
| outcome | output | 2 | 0 use core, 1 default NaN, 2 trap |
| exc_invalid | output | 1 | Invalid-operation trap raised |
| wr_en | output | 1 | Destination write allowed |
| qnan_out | output | 64 | Default quiet NaN for outcome 1, else zero |
| opnd_out | output | NSRC*64 | Screened operands for the core |
| core_valid | input | 1 | Core result present this cycle |
| core_res | input | 64 | Raw core result |
| res_valid | output | 1 | Post-processed result valid |
| res_out | output | 64 | Post-processed result |

## Verification
The hardest case to reach is a signalling NaN and a quiet NaN arriving together in the same instruction, under each setting of the trap enable, while a third value is used for the other lane. The same goes for a NaN sitting in a lane whose use flag is clear. Uniform random 64-bit words almost never produce NaNs or denormals. To get around that, the stimulus first picks a class for each operand and then builds the bit pattern from it: exponent field, fraction MSB and a non-zero fraction. Class, precision, operation kind, use mask and both mode bits are drawn independently. Directed cases cover the trap-priority, infinity and masked-lane cases explicitly.

// File: rtl/fpsu_pkg.sv
package fpsu_pkg;
   localparam int unsigned SP_EXP_W  = 8;
   localparam int unsigned SP_FRAC_W = 23;
   localparam int unsigned DP_EXP_W  = 11;
   localparam int unsigned DP_FRAC_W = 52;
   localparam int unsigned LANE_W    = 64;
   localparam int unsigned SP_W      = SP_EXP_W + SP_FRAC_W + 1;
   localparam int unsigned CLS_W     = 3;

   localparam logic [LANE_W-1:0] SP_DFLT_QNAN = 64'h0000_0000_7FBF_FFFF;
   localparam logic [LANE_W-1:0] DP_DFLT_QNAN = 64'h7FF7_FFFF_FFFF_FFFF;

   typedef enum logic [CLS_W-1:0] {
      FC_ZERO   = 3'd0,
      FC_DENORM = 3'd1,
      FC_NORMAL = 3'd2,
      FC_INF    = 3'd3,
      FC_QNAN   = 3'd4,
      FC_SNAN   = 3'd5
   } fclass_e;

   typedef enum logic [1:0] {
      OPK_ARITH = 2'd0,
      OPK_COPY  = 2'd1,
      OPK_ABS   = 2'd2,
      OPK_NEG   = 2'd3
   } opk_e;

   typedef enum logic [1:0] {
      OUT_CORE = 2'd0,
      OUT_QNAN = 2'd1,
      OUT_TRAP = 2'd2
   } outc_e;
endpackage

// File: rtl/fpsu_classify.sv
module fpsu_classify
   import fpsu_pkg::*;
#(
   parameter int unsigned DATA_W = LANE_W
) (
   input  logic              dbl,
   input  logic [DATA_W-1:0] value,
   output logic [CLS_W-1:0]  cls
);
   localparam int unsigned NFMT = 2;

   if (DATA_W < LANE_W) begin : g_chk_w
      $error("fpsu_classify: DATA_W must hold a double-precision value");
   end

   // one field decoder per layout; index 1 is the 64-bit layout
   for (genvar f = 0; f < NFMT; f++) begin : g_fmt
      localparam int unsigned EW = (f == 1) ? DP_EXP_W  : SP_EXP_W;
      localparam int unsigned FW = (f == 1) ? DP_FRAC_W : SP_FRAC_W;
      logic [EW-1:0] ex;
      logic [FW-1:0] fr;
      fclass_e       c;
      assign ex = value[FW+EW-1:FW];
      assign fr = value[FW-1:0];
      always_comb begin
         if (&ex) begin
            if (fr == '0)          c = FC_INF;
            else if (fr[FW-1])     c = FC_SNAN;
            else                   c = FC_QNAN;
         end else if (ex == '0) begin
            c = (fr == '0) ? FC_ZERO : FC_DENORM;
         end else begin
            c = FC_NORMAL;
         end
      end
   end

   assign cls = dbl ? g_fmt[1].c : g_fmt[0].c;
endmodule

// File: rtl/fpsu_flush.sv
module fpsu_flush
   import fpsu_pkg::*;
#(
   parameter int unsigned DATA_W = LANE_W
) (
   input  logic              dbl,
   input  logic              en,
   input  logic [CLS_W-1:0]  cls,
   input  logic [DATA_W-1:0] value,
   output logic [DATA_W-1:0] out
);
   localparam int unsigned HI_W = DATA_W - SP_W;

   if (DATA_W <= SP_W) begin : g_chk_w
      $error("fpsu_flush: DATA_W must exceed the single-precision width");
   end

   logic [DATA_W-1:0] shaped;
   logic [DATA_W-1:0] signed_zero;

   always_comb begin
      if (dbl) begin
         shaped      = value;
         signed_zero = {value[DATA_W-1], {(DATA_W-1){1'b0}}};
      end else begin
         shaped      = {{HI_W{1'b0}}, value[SP_W-1:0]};
         signed_zero = {{HI_W{1'b0}}, value[SP_W-1], {(SP_W-1){1'b0}}};
      end
   end

   assign out = (en && fclass_e'(cls) == FC_DENORM) ? signed_zero : shaped;
endmodule

// File: rtl/fpsu_decide.sv
module fpsu_decide
   import fpsu_pkg::*;
#(
   parameter int unsigned NSRC = 2
) (
   input  logic [1:0]            op_kind,
   input  logic [NSRC-1:0]       use_mask,
   input  logic [NSRC*CLS_W-1:0] cls_flat,
   input  logic                  inv_en,
   output logic [1:0]            outcome,
   output logic                  any_snan,
   output logic                  any_qnan
);
   logic [NSRC-1:0] is_s;
   logic [NSRC-1:0] is_q;

   for (genvar i = 0; i < NSRC; i++) begin : g_src
      assign is_s[i] = use_mask[i] && (fclass_e'(cls_flat[i*CLS_W +: CLS_W]) == FC_SNAN);
      assign is_q[i] = use_mask[i] && (fclass_e'(cls_flat[i*CLS_W +: CLS_W]) == FC_QNAN);
   end

   assign any_snan = |is_s;
   assign any_qnan = |is_q;

   always_comb begin
      outcome = OUT_CORE;
      if (opk_e'(op_kind) == OPK_ARITH) begin
         if (any_snan)      outcome = inv_en ? OUT_TRAP : OUT_QNAN;
         else if (any_qnan) outcome = OUT_QNAN;
      end
   end
endmodule

// File: rtl/fp_special_unit.sv
module fp_special_unit
   import fpsu_pkg::*;
#(
   parameter int unsigned NSRC   = 2,
   parameter int unsigned DATA_W = 64
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   in_valid,
   input  logic                   dbl,
   input  logic [1:0]             op_kind,
   input  logic [NSRC-1:0]        use_mask,
   input  logic                   inv_en,
   input  logic                   flush_en,
   input  logic [NSRC*DATA_W-1:0] opnd_in,
   output logic                   dec_valid,
   output logic [1:0]             outcome,
   output logic                   exc_invalid,
   output logic                   wr_en,
   output logic [DATA_W-1:0]      qnan_out,
   output logic [NSRC*DATA_W-1:0] opnd_out,
   input  logic                   core_valid,
   input  logic [DATA_W-1:0]      core_res,
   output logic                   res_valid,
   output logic [DATA_W-1:0]      res_out
);
   localparam int unsigned BUS_W = NSRC * DATA_W;

   if (DATA_W != LANE_W) begin : g_chk_w
      $error("fp_special_unit: DATA_W must equal 64");
   end
   if (NSRC < 1 || NSRC > 2) begin : g_chk_n
      $error("fp_special_unit: NSRC must be 1 or 2");
   end

   logic arith;
   assign arith = (opk_e'(op_kind) == OPK_ARITH);

   // ---------------- operand side ----------------
   logic [NSRC*CLS_W-1:0] src_cls;
   logic [BUS_W-1:0]      src_fl;

   for (genvar i = 0; i < NSRC; i++) begin : g_lane
      logic [CLS_W-1:0] c;
      fpsu_classify #(.DATA_W(DATA_W)) u_cls (
         .dbl   (dbl),
         .value (opnd_in[i*DATA_W +: DATA_W]),
         .cls   (c)
      );
      assign src_cls[i*CLS_W +: CLS_W] = c;
      fpsu_flush #(.DATA_W(DATA_W)) u_fl (
         .dbl   (dbl),
         .en    (flush_en && arith && use_mask[i]),
         .cls   (c),
         .value (opnd_in[i*DATA_W +: DATA_W]),
         .out   (src_fl[i*DATA_W +: DATA_W])
      );
   end

   logic [1:0] nxt_outc;
   logic       any_snan;
   logic       any_qnan;

   fpsu_decide #(.NSRC(NSRC)) u_dec (
      .op_kind  (op_kind),
      .use_mask (use_mask),
      .cls_flat (src_cls),
      .inv_en   (inv_en),
      .outcome  (nxt_outc),
      .any_snan (any_snan),
      .any_qnan (any_qnan)
   );

   logic [DATA_W-1:0] nxt_qn;
   always_comb begin
      nxt_qn = '0;
      if (outc_e'(nxt_outc) == OUT_QNAN) nxt_qn = dbl ? DP_DFLT_QNAN : SP_DFLT_QNAN;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dec_valid   <= 1'b0;
         outcome     <= OUT_CORE;
         exc_invalid <= 1'b0;
         wr_en       <= 1'b0;
         qnan_out    <= '0;
         opnd_out    <= '0;
      end else begin
         dec_valid <= in_valid;
         if (in_valid) begin
            outcome     <= nxt_outc;
            exc_invalid <= (outc_e'(nxt_outc) == OUT_TRAP);
            wr_en       <= (outc_e'(nxt_outc) != OUT_TRAP);
            qnan_out    <= nxt_qn;
            opnd_out    <= src_fl;
         end
      end
   end

   // ---------------- result side ----------------
   logic [CLS_W-1:0]  res_cls;
   logic [DATA_W-1:0] res_fl;

   fpsu_classify #(.DATA_W(DATA_W)) u_rcls (
      .dbl   (dbl),
      .value (core_res),
      .cls   (res_cls)
   );
   fpsu_flush #(.DATA_W(DATA_W)) u_rfl (
      .dbl   (dbl),
      .en    (flush_en && arith),
      .cls   (res_cls),
      .value (core_res),
      .out   (res_fl)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         res_out   <= '0;
      end else begin
         res_valid <= core_valid;
         if (core_valid) res_out <= res_fl;
      end
   end

   // ---------------- assertions ----------------
   AST_DEC_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> dec_valid); // R2
   AST_DEC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !dec_valid); // R2
   AST_SNAN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && arith && any_snan && !inv_en) |=> (outcome == OUT_QNAN && wr_en && !exc_invalid)); // R3
   AST_SNAN_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && arith && any_snan && inv_en) |=> (exc_invalid && !wr_en)); // R4
   AST_QNAN_NO_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && arith && any_qnan && !any_snan) |=> (!exc_invalid && wr_en)); // R5
   AST_TRANSFER_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !arith) |=> (outcome == OUT_CORE && !exc_invalid)); // R9
   AST_FLUSH_LANE0: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && arith && flush_en && use_mask[0] && fclass_e'(src_cls[CLS_W-1:0]) == FC_DENORM)
      |=> ($past(dbl) ? (opnd_out[DATA_W-2:0] == '0) : (opnd_out[SP_W-2:0] == '0))); // R7
   AST_SINGLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !dbl) |=> (opnd_out[DATA_W-1:SP_W] == '0 && qnan_out[DATA_W-1:SP_W] == '0)); // R11
   AST_RES_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      core_valid |=> res_valid); // R8
endmodule

// File: tb/fp_special_unit_test.sv
`timescale 1ns/1ps
module fp_special_unit_test;
   localparam int NS = 2;
   localparam logic [63:0] SPQ = 64'h0000_0000_7FBF_FFFF;
   localparam logic [63:0] DPQ = 64'h7FF7_FFFF_FFFF_FFFF;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0, dbl = 1'b0, inv_en = 1'b0, flush_en = 1'b0;
   logic [1:0] op_kind = 2'd0;
   logic [NS-1:0] use_mask = '0;
   logic [NS*64-1:0] opnd_in = '0;
   logic core_valid = 1'b0;
   logic [63:0] core_res = '0;
   logic dec_valid, exc_invalid, wr_en, res_valid;
   logic [1:0] outcome;
   logic [63:0] qnan_out, res_out;
   logic [NS*64-1:0] opnd_out;

   int n_chk = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   fp_special_unit #(.NSRC(NS), .DATA_W(64)) uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .dbl(dbl), .op_kind(op_kind),
      .use_mask(use_mask), .inv_en(inv_en), .flush_en(flush_en), .opnd_in(opnd_in),
      .dec_valid(dec_valid), .outcome(outcome), .exc_invalid(exc_invalid), .wr_en(wr_en),
      .qnan_out(qnan_out), .opnd_out(opnd_out), .core_valid(core_valid),
      .core_res(core_res), .res_valid(res_valid), .res_out(res_out));

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // class codes: 0 zero 1 denormal 2 normal 3 inf 4 quiet 5 signalling
   function automatic int ref_cls(input bit d, input logic [63:0] v);
      logic [10:0] e; logic [51:0] f; bit eones, ezero, fmsb;
      if (d) begin e = v[62:52]; f = v[51:0]; eones = &e; ezero = (e == 0); fmsb = f[51]; end
      else begin e = {3'b0, v[30:23]}; f = {29'b0, v[22:0]}; eones = &v[30:23]; ezero = (v[30:23] == 0); fmsb = f[22]; end
      if (eones) return (f == 0) ? 3 : (fmsb ? 5 : 4);
      if (ezero) return (f == 0) ? 0 : 1;
      return 2;
   endfunction

   function automatic logic [63:0] mk(input bit d, input int k);
      logic [63:0] r; logic s; logic [10:0] e; logic [51:0] f; logic [7:0] e8; logic [22:0] f8;
      r = {$urandom(), $urandom()};
      s = r[63];
      if (d) begin
         f = {$urandom(), $urandom()};
         case (k)
            0: begin e = 0; f = 0; end
            1: begin e = 0; if (f == 0) f = 1; end
            2: e = 11'($urandom_range(2046, 1));
            3: begin e = '1; f = 0; end
            4: begin e = '1; f[51] = 1'b0; if (f == 0) f = 1; end
            default: begin e = '1; f[51] = 1'b1; end
         endcase
         return {s, e, f};
      end
      f8 = 23'($urandom());
      case (k)
         0: begin e8 = 0; f8 = 0; end
         1: begin e8 = 0; if (f8 == 0) f8 = 1; end
         2: e8 = 8'($urandom_range(254, 1));
         3: begin e8 = '1; f8 = 0; end
         4: begin e8 = '1; f8[22] = 1'b0; if (f8 == 0) f8 = 1; end
         default: begin e8 = '1; f8[22] = 1'b1; end
      endcase
      return {r[31:0], s, e8, f8};
   endfunction

   function automatic logic [63:0] ref_flush(input bit d, input bit en, input logic [63:0] v);
      logic [63:0] b;
      b = d ? v : {32'b0, v[31:0]};
      if (en && ref_cls(d, v) == 1) b = d ? {v[63], 63'b0} : {32'b0, v[31], 31'b0};
      return b;
   endfunction

   task automatic run_op(input bit d, input logic [1:0] ok, input logic [NS-1:0] um,
                         input bit ie, input bit fe, input logic [63:0] a, input logic [63:0] b,
                         input logic [63:0] cr);
      bit ar, as, aq; int eo; string tag;
      logic [63:0] v [NS];
      v[0] = a; v[1] = b;
      ar = (ok == 2'd0); as = 0; aq = 0;
      for (int i = 0; i < NS; i++) begin
         if (um[i] && ref_cls(d, v[i]) == 5) as = 1;
         if (um[i] && ref_cls(d, v[i]) == 4) aq = 1;
      end
      if (!ar) begin eo = 0; tag = "R9"; end
      else if (as) begin eo = ie ? 2 : 1; tag = ie ? "R4 R1" : "R3 R1"; end
      else if (aq) begin eo = 1; tag = "R5 R1"; end
      else begin eo = 0; tag = "R12 outcome"; end
      @(negedge clk);
      in_valid = 1; dbl = d; op_kind = ok; use_mask = um; inv_en = ie; flush_en = fe;
      opnd_in = {b, a}; core_valid = 1; core_res = cr;
      @(negedge clk);
      in_valid = 0; core_valid = 0;
      chk("R2 dec_valid", {63'b0, dec_valid}, 64'd1);
      chk(tag, {62'b0, outcome}, 64'(eo));
      chk("R4 exc_invalid", {63'b0, exc_invalid}, {63'b0, eo == 2});
      chk("R4 wr_en", {63'b0, wr_en}, {63'b0, eo != 2});
      chk("R6 qnan_out", qnan_out, (eo == 1) ? (d ? DPQ : SPQ) : 64'd0);
      for (int i = 0; i < NS; i++)
         chk(!ar ? "R9 opnd" : (!um[i] ? "R10 opnd" : (d ? "R7 opnd" : "R11 R7 opnd")),
             opnd_out[i*64 +: 64], ref_flush(d, fe && ar && um[i], v[i]));
      chk("R8 res_valid", {63'b0, res_valid}, 64'd1);
      chk("R8 res_out", res_out, ref_flush(d, fe && ar, cr));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      chk("R2 reset dec_valid", {63'b0, dec_valid}, 64'd0);
      chk("R2 reset wr_en", {63'b0, wr_en}, 64'd0);
      chk("R2 reset res_valid", {63'b0, res_valid}, 64'd0);
      chk("R2 reset opnd_out", opnd_out[63:0], 64'd0);
      rst_n = 1;
      // directed corners
      run_op(0, 2'd0, 2'b11, 1, 0, mk(0, 5), mk(0, 2), mk(0, 2));   // R4 trap
      chk("R2 dec_valid idle", {63'b0, dec_valid}, 64'd1);
      @(negedge clk);
      chk("R2 dec_valid drops", {63'b0, dec_valid}, 64'd0);
      run_op(0, 2'd0, 2'b11, 0, 0, mk(0, 5), mk(0, 2), mk(0, 2));   // R3
      run_op(1, 2'd0, 2'b11, 1, 0, mk(1, 4), mk(1, 2), mk(1, 2));   // R5, R6 double
      run_op(1, 2'd0, 2'b11, 1, 0, mk(1, 4), mk(1, 5), mk(1, 2));   // R4 priority
      run_op(0, 2'd0, 2'b11, 1, 0, mk(0, 3), mk(0, 3), mk(0, 3));   // R12
      run_op(1, 2'd0, 2'b11, 0, 1, mk(1, 1), mk(0, 1), mk(1, 1));   // R7 / R8 flush
      run_op(1, 2'd0, 2'b11, 0, 0, mk(1, 1), mk(1, 1), mk(1, 1));   // R7 no flush
      run_op(0, 2'd2, 2'b11, 1, 1, mk(0, 5), mk(0, 1), mk(0, 1));   // R9
      run_op(0, 2'd0, 2'b01, 1, 1, mk(0, 2), mk(0, 5), mk(0, 2));   // R10
      run_op(0, 2'd0, 2'b01, 1, 1, mk(0, 2), mk(0, 1), mk(0, 2));   // R10 flush
      run_op(0, 2'd0, 2'b11, 0, 1, 64'hFFFF_FFFF_8000_0001, 64'hDEAD_BEEF_0000_0000, 64'hFFFF_0000_3F80_0000); // R11
      chk("R11 high half", opnd_out[63:32], 64'd0);
      // constrained random
      for (int n = 0; n < 400; n++) begin
         bit d; d = 1'($urandom());
         run_op(d, 2'($urandom()), 2'($urandom()), 1'($urandom()), 1'($urandom()),
                mk(d, int'($urandom_range(5, 0))), mk(d, int'($urandom_range(5, 0))),
                mk(d, int'($urandom_range(5, 0))));
      end
      @(negedge clk);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule